// File: doc/BRIEF.md
# Adaptive Delta Modulation Codec

This block is a digital adaptive delta modulation encoder with its matching decoder. It takes a signed multi-bit sample on each clock cycle in which the sample strobe is high. It compares that sample with a running estimate and sends out one bit per sample, telling whether the sample lies above the estimate. After each decision the estimate moves by a step. The step itself grows while the bits keep repeating and shrinks while they keep flipping. This lets the estimate chase steep slopes quickly and then settle with little ripple when the input is flat.

The decoder receives the bit stream together with its valid strobe and applies the same arithmetic to its own copy of the estimate and step. Fed with the encoder's own output, it rebuilds exactly the value the encoder holds, one cycle later. The estimate saturates at the signed full-scale limits instead of wrapping around. The step always stays between two parameters, a minimum and a maximum.

Top module: `adm_codec`

## Requirements
- R1: For each accepted sample the produced bit is 1 when the sample is strictly greater than the encoder estimate, as signed values, and 0 otherwise, including when they are equal.
- R2: A sample presented with `smp_valid` high on one clock edge makes its bit appear on `bit_out` with `bit_valid` high after that same edge. `bit_valid` is high for exactly one cycle per accepted sample.
- R3: On each accepted sample the encoder estimate rises by the current step when the bit is 1 and falls by the current step when the bit is 0. The current step is the one held before the sample.
- R4: When the new bit equals the previous bit, the step doubles for the next sample, capped at `STEP_MAX`.
- R5: When the new bit differs from the previous bit, the step halves (integer division) for the next sample, floored at `STEP_MIN`.
- R6: The estimate saturates at -2^(DW-1) and 2^(DW-1)-1 and never wraps.
- R7: Synchronous reset (`rst` high) clears both estimates to 0, sets both steps to `STEP_MIN` and both previous bits to 0, and drives `bit_out` and `bit_valid` to 0.
- R8: A cycle with `smp_valid` low leaves the encoder estimate, step and history unchanged. On the next edge it drives `bit_valid` low and leaves `bit_out` holding its last value.
- R9: On the edge after `bit_valid` is high, the decoder consumes the bit with the same rule. `recon_out` then equals, bit for bit, the encoder estimate produced by that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe; the sample is accepted on this edge |
| smp_in | input | DW | Signed input sample |
| bit_out | output | 1 | Encoded bit, 1 = sample above estimate |
| bit_valid | output | 1 | High for one cycle with each new encoded bit |
| recon_out | output | DW | Signed decoder reconstruction |

## Verification
Every possible input value is held constant from reset. This separates the growth of the step on the first approach from the decay into minimum-step granular toggling once the estimate reaches the input. Full-scale jumps between the two extremes drive the step to its cap and the estimate into both saturation limits, which catches wrap-around. Triangle ramps of different slopes test tracking with a step that keeps changing. A pseudo-random run with gaps in the strobe checks that idle cycles freeze the state and that the decoder stays in lockstep with the encoder.

// File: rtl/adm_pkg.sv
package adm_pkg;

  // Estimate after one move by step, up when up is set, clamped to [lo, hi].
  function automatic int adm_move(input int est, input int step, input logic up,
                                  input int lo, input int hi);
    int nxt;
    nxt = up ? est + step : est - step;
    if (nxt > hi) nxt = hi;
    if (nxt < lo) nxt = lo;
    return nxt;
  endfunction

  // Step for the next update: doubled on a repeated bit, halved on a flip.
  function automatic int adm_adapt(input int step, input logic same,
                                   input int smin, input int smax);
    int nxt;
    if (same) nxt = (step * 2 > smax) ? smax : step * 2;
    else      nxt = (step / 2 < smin) ? smin : step / 2;
    return nxt;
  endfunction

endpackage

// File: rtl/adm_track.sv
module adm_track #(
  parameter int DW       = 8,
  parameter int STEP_MIN = 1,
  parameter int STEP_MAX = 32,
  localparam int SW      = $clog2(STEP_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 bit_in,
  output logic signed [DW-1:0] est_o,
  output logic [SW-1:0]        step_o
);
  localparam int EST_HI = (2 ** (DW - 1)) - 1;
  localparam int EST_LO = -(2 ** (DW - 1));

  logic signed [DW-1:0] est_q;
  logic [SW-1:0]        step_q;
  logic                 prev_q;
  logic                 same_bit;

  assign same_bit = (bit_in == prev_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      est_q  <= '0;
      step_q <= SW'(STEP_MIN);
      prev_q <= 1'b0;
    end else if (tick) begin
      est_q  <= DW'(adm_pkg::adm_move(int'(est_q), int'(step_q), bit_in, EST_LO, EST_HI));
      step_q <= SW'(adm_pkg::adm_adapt(int'(step_q), same_bit, STEP_MIN, STEP_MAX));
      prev_q <= bit_in;
    end
  end

  assign est_o  = est_q;
  assign step_o = step_q;
endmodule

// File: rtl/adm_encoder.sv
module adm_encoder #(
  parameter int DW       = 8,
  parameter int STEP_MIN = 1,
  parameter int STEP_MAX = 32,
  localparam int SW      = $clog2(STEP_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_valid,
  input  logic signed [DW-1:0] smp_in,
  output logic                 bit_q,
  output logic                 bv_q,
  output logic signed [DW-1:0] est_o,
  output logic [SW-1:0]        step_o
);
  logic above;

  assign above = (smp_in > est_o);

  adm_track #(.DW(DW), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX)) u_track (
    .clk(clk), .rst(rst), .tick(smp_valid), .bit_in(above),
    .est_o(est_o), .step_o(step_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= 1'b0;
      bv_q  <= 1'b0;
    end else begin
      bv_q <= smp_valid;
      if (smp_valid) bit_q <= above;
    end
  end
endmodule

// File: rtl/adm_decoder.sv
module adm_decoder #(
  parameter int DW       = 8,
  parameter int STEP_MIN = 1,
  parameter int STEP_MAX = 32,
  localparam int SW      = $clog2(STEP_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bit_in,
  input  logic                 bit_valid,
  output logic signed [DW-1:0] est_o,
  output logic [SW-1:0]        step_o
);
  adm_track #(.DW(DW), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX)) u_track (
    .clk(clk), .rst(rst), .tick(bit_valid), .bit_in(bit_in),
    .est_o(est_o), .step_o(step_o)
  );
endmodule

// File: rtl/adm_codec.sv
module adm_codec #(
  parameter int DW       = 8,
  parameter int STEP_MIN = 1,
  parameter int STEP_MAX = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_valid,
  input  logic signed [DW-1:0] smp_in,
  output logic                 bit_out,
  output logic                 bit_valid,
  output logic signed [DW-1:0] recon_out
);
  localparam int SW = $clog2(STEP_MAX + 1);

  logic signed [DW-1:0] enc_est;
  logic [SW-1:0]        enc_step;
  logic signed [DW-1:0] dec_est;
  logic [SW-1:0]        dec_step;

  adm_encoder #(.DW(DW), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX)) u_enc (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_in(smp_in),
    .bit_q(bit_out), .bv_q(bit_valid), .est_o(enc_est), .step_o(enc_step)
  );

  adm_decoder #(.DW(DW), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX)) u_dec (
    .clk(clk), .rst(rst), .bit_in(bit_out), .bit_valid(bit_valid),
    .est_o(dec_est), .step_o(dec_step)
  );

  assign recon_out = dec_est;
endmodule

// File: rtl/adm_codec_chk.sv
module adm_codec_chk #(
  parameter int DW       = 8,
  parameter int STEP_MIN = 1,
  parameter int STEP_MAX = 32,
  localparam int SW      = $clog2(STEP_MAX + 1)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 smp_valid,
  input logic signed [DW-1:0] smp_in,
  input logic                 bit_valid,
  input logic signed [DW-1:0] enc_est,
  input logic [SW-1:0]        enc_step,
  input logic signed [DW-1:0] dec_est,
  input logic [SW-1:0]        dec_step
);
  a_r2_valid_on: assert property (@(posedge clk) disable iff (rst)
    smp_valid |=> bit_valid);
  a_r2_valid_off: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> !bit_valid);
  a_r4_step_bounds: assert property (@(posedge clk) disable iff (rst)
    enc_step >= SW'(STEP_MIN) && enc_step <= SW'(STEP_MAX) &&
    dec_step >= SW'(STEP_MIN) && dec_step <= SW'(STEP_MAX));
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> $stable(enc_est) && $stable(enc_step));
  a_r6_no_wrap_up: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && smp_in > enc_est) |=> enc_est >= $past(enc_est));
  a_r6_no_wrap_down: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !(smp_in > enc_est)) |=> enc_est <= $past(enc_est));
  a_r9_lockstep: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> dec_est == $past(enc_est));
endmodule

bind adm_codec adm_codec_chk #(.DW(DW), .STEP_MIN(STEP_MIN), .STEP_MAX(STEP_MAX)) u_chk (
  .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_in(smp_in),
  .bit_valid(bit_valid), .enc_est(enc_est), .enc_step(enc_step),
  .dec_est(dec_est), .dec_step(dec_step)
);

// File: tb/adm_codec_test.sv
module adm_codec_test;
  localparam int DW = 8;
  localparam int SMIN = 1;
  localparam int SMAX = 32;
  localparam int HI = 127;
  localparam int LO = -128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0;
  logic signed [DW-1:0] smp_in = '0;
  logic bit_out, bit_valid;
  logic signed [DW-1:0] recon_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // bench-side model of the codec
  int m_est, m_step, m_prev, m_bit, m_bv, d_exp;
  string tag = "R9";

  always #4 clk = ~clk;

  adm_codec #(.DW(DW), .STEP_MIN(SMIN), .STEP_MAX(SMAX)) uut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_in(smp_in),
    .bit_out(bit_out), .bit_valid(bit_valid), .recon_out(recon_out)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; smp_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_est = 0; m_step = SMIN; m_prev = 0; m_bit = 0; m_bv = 0; d_exp = 0;
    // R7: reset state at the ports
    check("R7 bit_out", int'(bit_out), 0);
    check("R7 bit_valid", int'(bit_valid), 0);
    check("R7 recon_out", int'(recon_out), 0);
  endtask

  // called at a falling edge; drives, waits an edge, updates model, checks
  task automatic cyc(input bit v, input int x);
    int b, t;
    smp_valid = v;
    smp_in = DW'(x);
    @(posedge clk);
    if (m_bv != 0) d_exp = m_est;       // decoder consumes previous bit (R9)
    if (v) begin
      b = (x > m_est) ? 1 : 0;           // R1
      t = (b == 1) ? m_est + m_step : m_est - m_step;   // R3
      if (t > HI) t = HI;                // R6
      if (t < LO) t = LO;
      m_est = t;
      if (b == m_prev) begin             // R4
        m_step = m_step * 2;
        if (m_step > SMAX) m_step = SMAX;
      end else begin                     // R5
        m_step = m_step >> 1;
        if (m_step < SMIN) m_step = SMIN;
      end
      m_prev = b;
      m_bit = b;
    end
    m_bv = v ? 1 : 0;
    @(negedge clk);
    check(v ? "R1 R2 bit_out" : "R8 bit_out held", int'(bit_out), m_bit);
    check(v ? "R2 bit_valid" : "R8 bit_valid", int'(bit_valid), m_bv);
    check(tag, int'(recon_out), d_exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int lcg;
    do_reset();

    // every constant input from reset: growth then granular decay (R3 R4 R5 R9)
    tag = "R3 R4 R5 R9 recon_out";
    for (int v = LO; v <= HI; v++) begin
      do_reset();
      repeat (24) cyc(1'b1, v);
      cyc(1'b0, 0);
    end

    // full-scale jumps: step cap and saturation at both ends (R4 R6)
    tag = "R4 R6 R9 recon_out";
    do_reset();
    for (int k = 0; k < 6; k++) begin
      repeat (20) cyc(1'b1, HI);
      repeat (20) cyc(1'b1, LO);
    end

    // triangle ramps of two slopes (R3 R4 R5)
    tag = "R3 R4 R5 R9 ramp";
    for (int s = 3; s <= 12; s += 9) begin
      int x, d;
      do_reset();
      x = 0; d = s;
      for (int k = 0; k < 400; k++) begin
        cyc(1'b1, x);
        x += d;
        if (x > 120) begin x = 120; d = -s; end
        if (x < -120) begin x = -120; d = s; end
      end
    end

    // pseudo-random samples with strobe gaps (R8 R9)
    tag = "R8 R9 random";
    do_reset();
    lcg = 12345;
    for (int k = 0; k < 3000; k++) begin
      lcg = lcg * 1103515245 + 12345;
      cyc(((lcg >>> 20) & 3) != 0, ((lcg >>> 8) & 255) - 128);
    end
    cyc(1'b0, 0);
    cyc(1'b0, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule